// File: doc/BRIEF.md
# Dual-Edge Capture Timer

This block runs a free-counting timer from the system clock and watches one external capture pin. After the pin has been brought into the clock domain and held its new level for long enough to count as a real transition, the block stores the current timer value: a rise goes into one holding register and a fall into another. Software can subtract the two to get a pulse width, or subtract two captures of the same polarity to get a period. All timer arithmetic is modulo 2^16.

Every accepted edge sets a sticky interrupt flag, which drives the interrupt request line. A status word records which polarity was captured last. It also flags an overrun when a capture lands while the interrupt flag is still set. Software reads the timer, the two capture registers and the status word through a small register port, and clears the flag and the overrun by writing to the status address. A count-enable input can freeze the timer.

The total delay from a pin transition to the capture and to the interrupt is fixed at four clock edges. Because of that fixed delay, software sees the same offset on every timestamp, and the offset cancels when two timestamps are subtracted.

Top module: `ecap_top`

## Requirements
- R1: While `rst` is high at a clock edge, the timer, both capture registers and the status word are cleared to 0, and `irq` is 0.
- R2: The timer increases by one on each clock edge while `cnt_en` is 1. It holds its value while `cnt_en` is 0. It wraps from 0xFFFF to 0x0000.
- R3: When `cap_pin` goes from 0 to 1 just after clock edge 0 and stays high for at least 4 clocks, the rise register is loaded on clock edge 4. The value loaded is the timer value that was present just before that edge. The fall register does not change.
- R4: A 1-to-0 transition held for at least 4 clocks loads the fall register under the same timing as R3. The rise register does not change.
- R5: `irq` goes to 1 on the same clock edge on which the capture happens, that is edge 4 after the transition. It then stays at 1 until software clears it.
- R6: A pin pulse that lasts only one clock is ignored: no capture register changes and `irq` stays at 0.
- R7: Status bit 1 is 1 when the last capture came from a rise and 0 when it came from a fall. Status bit 0 is the interrupt flag and mirrors `irq`.
- R8: A capture that happens while the flag is still set sets status bit 2 (overrun). A write to address 3 clears the flag if `bus_wdata[0]` is 1 and clears the overrun if `bus_wdata[1]` is 1.
- R9: The read address selects the register: 0 gives the timer, 1 the rise capture, 2 the fall capture, and 3 the status word with zeros above bit 2. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Timer count enable |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_addr | input | 2 | Register select for reads and writes |
| bus_wr | input | 1 | Write strobe (status address only) |
| bus_wdata | input | 2 | Write data: bit 0 clears flag, bit 1 clears overrun |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Sticky capture interrupt request |

## Verification
The pin is driven with clean levels held for 6, 7, 10 and 25 clocks, in alternating polarity. These runs show that each polarity reaches its own register, that the fixed four-edge delay holds, and that the last-edge bit follows the polarity. A one-clock spike shows that short glitches are rejected and do not alter any register. A rise followed by a fall with no clear in between separates the overrun path from normal captures. Freezing the enable, and running the timer through 0xFFFF, cover the hold and wrap behaviour of the counter.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int STAT_BITS = 3;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_RISE  = 2'd1,
        SEL_FALL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ovf;
        logic last_rise;
        logic flag;
    } stat_t;

    typedef struct packed {
        logic fire;
        logic rising;
    } edge_evt_t;

    function automatic logic [STAT_BITS-1:0] stat_bits(stat_t s);
        return {s.ovf, s.last_rise, s.flag};
    endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ecap_qual.sv
module ecap_qual
    import ecap_pkg::*;
#(
    parameter int RUN = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_in,
    output edge_evt_t evt
);
    localparam int RUN_W = (RUN > 1) ? $clog2(RUN) : 1;

    logic             level;
    logic [RUN_W-1:0] run;
    logic             differs;

    assign differs    = (lvl_in != level);
    assign evt.fire   = differs && (run == RUN_W'(RUN - 1));
    assign evt.rising = lvl_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            run   <= '0;
        end else if (!differs) begin
            run <= '0;
        end else if (evt.fire) begin
            level <= lvl_in;
            run   <= '0;
        end else begin
            run <= run + RUN_W'(1);
        end
    end

    // R6: an accepted edge must have been seen on two consecutive samples
    assert_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        evt.fire |-> (lvl_in == $past(lvl_in)));

    // R6: after an accepted edge the tracked level has moved
    assert_level_moves_R6: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> (level != $past(level)));
endmodule

// File: rtl/ecap_regs.sv
module ecap_regs
    import ecap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  edge_evt_t        evt,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic [1:0]       wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] rise_q;
    logic [CNT_W-1:0] fall_q;
    stat_t            stat;
    logic             clr_flag;
    logic             clr_ovf;

    assign clr_flag = wr && (reg_sel_e'(addr) == SEL_STAT) && wdata[0];
    assign clr_ovf  = wr && (reg_sel_e'(addr) == SEL_STAT) && wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_en) begin
            count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            fall_q <= '0;
            stat   <= '0;
        end else begin
            if (evt.fire) begin
                if (evt.rising) rise_q <= count;
                else            fall_q <= count;
                stat.last_rise <= evt.rising;
            end
            if (evt.fire)     stat.flag <= 1'b1;
            else if (clr_flag) stat.flag <= 1'b0;
            if (evt.fire && stat.flag && !clr_flag) stat.ovf <= 1'b1;
            else if (clr_ovf)                       stat.ovf <= 1'b0;
        end
    end

    assign irq = stat.flag;

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_COUNT: rdata = count;
            SEL_RISE:  rdata = rise_q;
            SEL_FALL:  rdata = fall_q;
            default:   rdata = {{(CNT_W-STAT_BITS){1'b0}}, stat_bits(stat)};
        endcase
    end

    // R5: a new interrupt only follows an accepted edge
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt.fire));

    // R3: the rise register only moves on a rising capture
    assert_rise_only_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(rise_q) |-> $past(evt.fire && evt.rising));

    // R4: the fall register only moves on a falling capture
    assert_fall_only_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(fall_q) |-> $past(evt.fire && !evt.rising));

    // R8: overrun only appears when the flag was already pending
    assert_ovf_pending_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.ovf) |-> $past(irq));
endmodule

// File: rtl/ecap_top.sv
module ecap_top
    import ecap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int LATENCY     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             cap_pin,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [1:0]       bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int QUAL_RUN = LATENCY - SYNC_STAGES;

    logic      pin_sync;
    edge_evt_t evt;

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap_pin),
        .q   (pin_sync)
    );

    ecap_qual #(.RUN(QUAL_RUN)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (pin_sync),
        .evt    (evt)
    );

    ecap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .evt    (evt),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .irq    (irq)
    );
endmodule

// File: tb/ecap_top_tb.sv
module ecap_top_tb;

    typedef struct {
        logic        rising;
        logic [15:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic        cap = 1'b0;
    logic [1:0]  main_addr = 2'd0, mon_addr = 2'd0;
    logic        main_wr = 1'b0, mon_wr = 1'b0;
    logic [1:0]  main_wd = 2'd0, mon_wd = 2'd0;
    logic        mon_active = 1'b0;
    logic        mon_on = 1'b1;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [1:0]  bus_wdata;
    logic [15:0] rdata;
    logic        irq;
    logic [15:0] m;
    logic [15:0] last_val = 16'd0;
    logic        irq_prev = 1'b0;
    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    assign bus_addr  = mon_active ? mon_addr : main_addr;
    assign bus_wr    = mon_active ? mon_wr   : main_wr;
    assign bus_wdata = mon_active ? mon_wd   : main_wd;

    ecap_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (en),
        .cap_pin   (cap),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        if (rst)     m <= 16'd0;
        else if (en) m <= m + 16'd1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        main_addr = a;
        #1;
        v = rdata;
    endtask

    task automatic drive_edge(input logic v, input int hold);
        exp_t e;
        @(negedge clk);
        cap = v;
        repeat (3) @(negedge clk);
        last_val = m;
        e.rising = v;
        e.val    = m;
        if (mon_on) q.push_back(e);
        repeat (hold - 3) @(negedge clk);
    endtask

    // monitor: pops expected captures when a new interrupt appears
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (mon_on && irq && !irq_prev) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 unexpected irq", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    chk(m == e.val + 16'd1, "R5 irq latency", m, e.val + 16'd1);
                    mon_active = 1'b1;
                    mon_addr = e.rising ? 2'd1 : 2'd2;
                    #1;
                    chk(rdata == e.val, e.rising ? "R3 rise capture" : "R4 fall capture", rdata, e.val);
                    mon_addr = 2'd3;
                    #1;
                    chk(rdata[1] == e.rising, "R7 last edge bit", rdata[1], e.rising);
                    chk(rdata[2] == 1'b0, "R8 no overrun", rdata[2], 0);
                    mon_wd = 2'b11;
                    mon_wr = 1'b1;
                    @(negedge clk);
                    mon_wr = 1'b0;
                    mon_active = 1'b0;
                    chk(irq == 1'b0, "R8 flag cleared", irq, 0);
                end
            end
            irq_prev = irq;
        end
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, a, b, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 timer", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 rise", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 fall", v, 0);
        rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk(v == m, "R9 timer read", v, m);

        drive_edge(1'b1, 6);
        drive_edge(1'b0, 10);
        drive_edge(1'b1, 25);
        drive_edge(1'b0, 7);
        repeat (10) @(negedge clk);

        // R6 one-clock glitch
        rd(2'd1, r0);
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        repeat (10) @(negedge clk);
        chk(irq == 0, "R6 glitch irq", irq, 0);
        rd(2'd1, v); chk(v == r0, "R6 glitch rise reg", v, r0);
        rd(2'd3, v); chk(v == 0, "R6 glitch status", v, 0);

        // R8 overrun
        mon_on = 1'b0;
        drive_edge(1'b1, 8);
        drive_edge(1'b0, 8);
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk(v == 16'h5, "R8 overrun status", v, 16'h5);
        rd(2'd2, v); chk(v == last_val, "R4 fall under overrun", v, last_val);
        main_addr = 2'd3; main_wd = 2'b11; main_wr = 1'b1;
        @(negedge clk);
        main_wr = 1'b0;
        rd(2'd3, v); chk(v == 0, "R8 cleared status", v, 0);
        chk(irq == 0, "R8 irq cleared", irq, 0);
        @(negedge clk);
        irq_prev = 1'b0;
        mon_on = 1'b1;

        // R2 enable hold
        en = 1'b0;
        @(negedge clk);
        rd(2'd0, a);
        repeat (5) @(negedge clk);
        rd(2'd0, b);
        chk(a == b, "R2 hold", b, a);
        chk(b == m, "R2 value", b, m);
        en = 1'b1;

        // R2 wrap
        while (m != 16'hFFFE) @(negedge clk);
        rd(2'd0, v); chk(v == 16'hFFFE, "R2 pre-wrap", v, 16'hFFFE);
        @(negedge clk);
        rd(2'd0, v); chk(v == 16'hFFFF, "R2 top", v, 16'hFFFF);
        @(negedge clk);
        rd(2'd0, v); chk(v == 16'h0000, "R2 wrap", v, 0);

        chk(q.size() == 0, "R5 all captures seen", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule